// File: doc/BRIEF.md
# DRAM Bank Open/Idle State Tracker

This block keeps, on the memory-controller side, the state of each of eight DRAM banks: whether the bank holds an open row, is waiting out its precharge recovery time, or is idle and ready for a new row. It watches decoded command strobes together with a 3-bit bank address and an "all banks" qualifier that applies to precharge. Each bank has its own small state machine and a recovery down-counter. The block tells the scheduler which banks may take an ACTIVATE and which may take a READ or WRITE. It raises a violation pulse for any command that breaks the access rules.

Each bank state machine has three states. BK_IDLE means no row is open and recovery is over. BK_PRECHARGING means recovery is in progress and the counter is running. BK_ACTIVE means a row is open. The transitions are as follows. IDLE goes to ACTIVE on an ACTIVATE. IDLE goes to PRECHARGING on a PRECHARGE. ACTIVE goes to PRECHARGING on a PRECHARGE. PRECHARGING goes back to PRECHARGING on a PRECHARGE, which reloads the counter. PRECHARGING goes to IDLE when the counter has reached zero. Any other command leaves the state where it is. A PRECHARGE loads the counter with T_RP-1, so a bank is blocked for exactly T_RP cycles. The any-bank-active output is meant for power-down logic, which must know whether any row is still open.

Top module: `bank_state_tracker`

## Requirements
- R1: After reset every bank is BK_IDLE: act_ok is all ones, rw_ok is all zeros, any_bank_active is 0 and cmd_violation is 0.
- R2: An ACTIVATE (cmd_act) to a BK_IDLE bank makes that bank BK_ACTIVE from the next cycle. Its act_ok bit then clears and its rw_ok bit sets. act_ok and rw_ok bit i refers to bank i.
- R3: A PRECHARGE (cmd_pre) with pre_all=0 moves only the bank selected by bank_addr into BK_PRECHARGING. All other banks keep their state.
- R4: A PRECHARGE with pre_all=1 moves all eight banks into BK_PRECHARGING, whatever the value of bank_addr.
- R5: After a PRECHARGE a bank stays in BK_PRECHARGING for exactly T_RP cycles (default 4), with its act_ok bit low. An ACTIVATE in that window is a violation and does not open the bank.
- R6: An ACTIVATE to a bank that is already BK_ACTIVE is a violation, and the bank stays BK_ACTIVE.
- R7: A READ (cmd_rd) or WRITE (cmd_wr) to a BK_ACTIVE bank is legal and leaves the bank BK_ACTIVE. The same command to a bank that is not active is a violation and changes no state.
- R8: A PRECHARGE to a bank that is idle or already precharging is legal and restarts its T_RP window from that cycle.
- R9: any_bank_active is 1 exactly when at least one bank is BK_ACTIVE.
- R10: If more than one of cmd_act, cmd_rd, cmd_wr and cmd_pre is high in one cycle, this is a violation and no bank changes state.
- R11: cmd_violation is high for one cycle, in the cycle after the offending command. It is low after any legal command or idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_act | input | 1 | ACTIVATE strobe |
| cmd_rd | input | 1 | READ strobe |
| cmd_wr | input | 1 | WRITE strobe |
| cmd_pre | input | 1 | PRECHARGE strobe |
| pre_all | input | 1 | With cmd_pre: 1 selects all banks, 0 selects one bank |
| bank_addr | input | 3 | Target bank of the command |
| act_ok | output | 8 | Bit i high: bank i may take an ACTIVATE |
| rw_ok | output | 8 | Bit i high: bank i may take a READ or WRITE |
| any_bank_active | output | 1 | At least one bank has an open row |
| cmd_violation | output | 1 | One-cycle pulse flagging an illegal command |

## Verification
A table-driven command stream opens banks 0, 3 and 7. It reads and writes open banks and sends reads to idle banks, which separates legal accesses from the R7 violation. A single-bank precharge is followed by ACTIVATE attempts at the first cycle and at the last cycle of the recovery window, and then by one ACTIVATE right after it. This pins the window to exactly T_RP cycles and catches counter off-by-one errors. An all-bank precharge issued with a non-zero bank address shows whether bank_addr is really ignored, and a single-bank precharge to a bank that is still recovering shows whether its window restarts while the other banks finish on time. Doubled strobes and repeated bad commands check the R10 suppression and that the violation pulse ends on the next legal cycle.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;

    typedef enum logic [1:0] {
        BK_IDLE        = 2'd0,
        BK_PRECHARGING = 2'd1,
        BK_ACTIVE      = 2'd2
    } bank_st_e;

endpackage

// File: rtl/bank_cmd_decode.sv
module bank_cmd_decode #(
    parameter int NUM_BANKS = 8,
    localparam int BA_W = $clog2(NUM_BANKS)
) (
    input  logic                 cmd_act,
    input  logic                 cmd_rd,
    input  logic                 cmd_wr,
    input  logic                 cmd_pre,
    input  logic                 pre_all,
    input  logic [BA_W-1:0]      bank_addr,
    output logic [NUM_BANKS-1:0] act_hit,
    output logic [NUM_BANKS-1:0] rw_hit,
    output logic [NUM_BANKS-1:0] pre_hit,
    output logic                 multi_cmd
);

    logic [2:0] strobe_cnt;
    logic       single;

    always_comb begin
        strobe_cnt = 3'(cmd_act) + 3'(cmd_rd) + 3'(cmd_wr) + 3'(cmd_pre);
        multi_cmd  = (strobe_cnt > 3'd1);
        single     = !multi_cmd;
    end

    // One slice per bank: match the address, then gate by the strobe.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        assign sel        = (bank_addr == BA_W'(b));
        assign act_hit[b] = single && cmd_act && sel;
        assign rw_hit[b]  = single && (cmd_rd || cmd_wr) && sel;
        assign pre_hit[b] = single && cmd_pre && (pre_all || sel);
    end

endmodule

// File: rtl/bank_fsm.sv
module bank_fsm
    import bank_trk_pkg::*;
#(
    parameter int T_RP = 4,
    localparam int CW = (T_RP > 1) ? $clog2(T_RP) : 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     act_hit,
    input  logic     rw_hit,
    input  logic     pre_hit,
    output bank_st_e state_o,
    output logic     act_ok_o,
    output logic     rw_ok_o,
    output logic     bad_o
);

    localparam logic [CW-1:0] LOAD = CW'(T_RP - 1);

    bank_st_e        state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BK_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            BK_IDLE: begin
                if (pre_hit) begin
                    state_d = BK_PRECHARGING;
                    cnt_d   = LOAD;
                end else if (act_hit) begin
                    state_d = BK_ACTIVE;
                end
            end
            BK_PRECHARGING: begin
                if (pre_hit) begin
                    cnt_d = LOAD;
                end else if (cnt_q == '0) begin
                    state_d = BK_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            BK_ACTIVE: begin
                if (pre_hit) begin
                    state_d = BK_PRECHARGING;
                    cnt_d   = LOAD;
                end
            end
            default: begin
                state_d = BK_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        act_ok_o = 1'b0;
        rw_ok_o  = 1'b0;
        bad_o    = 1'b0;
        unique case (state_q)
            BK_IDLE: begin
                act_ok_o = 1'b1;
                bad_o    = rw_hit;
            end
            BK_PRECHARGING: begin
                bad_o = act_hit || rw_hit;
            end
            BK_ACTIVE: begin
                rw_ok_o = 1'b1;
                bad_o   = act_hit;
            end
            default: bad_o = 1'b0;
        endcase
    end

    assign state_o = state_q;

    assert_pre_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pre_hit |=> (state_q == BK_PRECHARGING && cnt_q == LOAD));

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BK_PRECHARGING) |-> (cnt_q <= LOAD));

    assert_wait_blocks_act_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_hit && state_q == BK_PRECHARGING) |=> (state_q != BK_ACTIVE));

    assert_reopen_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_hit && state_q == BK_ACTIVE) |=> (state_q == BK_ACTIVE));

    assert_rw_keeps_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rw_hit && state_q == BK_ACTIVE) |=> (state_q == BK_ACTIVE));

    assert_rw_no_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rw_hit && state_q != BK_ACTIVE) |=> (state_q != BK_ACTIVE));

endmodule

// File: rtl/bank_state_tracker.sv
module bank_state_tracker
    import bank_trk_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int T_RP      = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_act,
    input  logic                 cmd_rd,
    input  logic                 cmd_wr,
    input  logic                 cmd_pre,
    input  logic                 pre_all,
    input  logic [BA_W-1:0]      bank_addr,
    output logic [NUM_BANKS-1:0] act_ok,
    output logic [NUM_BANKS-1:0] rw_ok,
    output logic                 any_bank_active,
    output logic                 cmd_violation
);

    logic [NUM_BANKS-1:0] act_hit, rw_hit, pre_hit, bad_vec;
    logic                 multi_cmd;
    logic                 viol_q;
    bank_st_e             bank_st [NUM_BANKS];

    bank_cmd_decode #(.NUM_BANKS(NUM_BANKS)) u_decode (
        .cmd_act   (cmd_act),
        .cmd_rd    (cmd_rd),
        .cmd_wr    (cmd_wr),
        .cmd_pre   (cmd_pre),
        .pre_all   (pre_all),
        .bank_addr (bank_addr),
        .act_hit   (act_hit),
        .rw_hit    (rw_hit),
        .pre_hit   (pre_hit),
        .multi_cmd (multi_cmd)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_fsm
        bank_fsm #(.T_RP(T_RP)) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_hit  (act_hit[b]),
            .rw_hit   (rw_hit[b]),
            .pre_hit  (pre_hit[b]),
            .state_o  (bank_st[b]),
            .act_ok_o (act_ok[b]),
            .rw_ok_o  (rw_ok[b]),
            .bad_o    (bad_vec[b])
        );
    end

    // Violation register: one-cycle pulse after the offending command.
    always_ff @(posedge clk) begin
        if (!rst_n) viol_q <= 1'b0;
        else        viol_q <= multi_cmd || (|bad_vec);
    end

    always_comb begin
        any_bank_active = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++)
            any_bank_active = any_bank_active || (bank_st[b] == BK_ACTIVE);
    end

    assign cmd_violation = viol_q;

    assert_multi_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({cmd_act, cmd_rd, cmd_wr, cmd_pre}) > 1) |=> cmd_violation);

    assert_multi_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({cmd_act, cmd_rd, cmd_wr, cmd_pre}) > 1) |=> ($stable(rw_ok)));

    assert_pre_all_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pre && pre_all && !cmd_act && !cmd_rd && !cmd_wr)
            |=> (act_ok == '0 && rw_ok == '0 && !any_bank_active));

    assert_legal_no_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_act && !cmd_rd && !cmd_wr && !cmd_pre) |=> !cmd_violation);

endmodule

// File: tb/bank_state_tracker_tb.sv
module bank_state_tracker_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_act, cmd_rd, cmd_wr, cmd_pre, pre_all;
    logic [2:0] bank_addr;
    logic [7:0] act_ok, rw_ok;
    logic       any_bank_active, cmd_violation;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;   // 250 MHz

    bank_state_tracker #(.NUM_BANKS(8), .T_RP(4)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_pre(cmd_pre),
        .pre_all(pre_all), .bank_addr(bank_addr),
        .act_ok(act_ok), .rw_ok(rw_ok),
        .any_bank_active(any_bank_active), .cmd_violation(cmd_violation)
    );

    // {act,rd,wr,pre}, pre_all, bank, exp act_ok, exp rw_ok, exp violation
    localparam int NV = 23;
    localparam logic [24:0] VEC [NV] = '{
        {4'b1000, 1'b0, 3'd0, 8'hFE, 8'h01, 1'b0}, // 0  R2 open b0
        {4'b1000, 1'b0, 3'd3, 8'hF6, 8'h09, 1'b0}, // 1  R2 open b3
        {4'b0100, 1'b0, 3'd3, 8'hF6, 8'h09, 1'b0}, // 2  R7 read open
        {4'b0010, 1'b0, 3'd0, 8'hF6, 8'h09, 1'b0}, // 3  R7 write open
        {4'b0100, 1'b0, 3'd5, 8'hF6, 8'h09, 1'b1}, // 4  R7 read idle
        {4'b1000, 1'b0, 3'd0, 8'hF6, 8'h09, 1'b1}, // 5  R6 reopen
        {4'b0001, 1'b0, 3'd0, 8'hF6, 8'h08, 1'b0}, // 6  R3 close b0
        {4'b1000, 1'b0, 3'd0, 8'hF6, 8'h08, 1'b1}, // 7  R5 act in window
        {4'b0000, 1'b0, 3'd0, 8'hF6, 8'h08, 1'b0}, // 8  R11 pulse ends
        {4'b0000, 1'b0, 3'd0, 8'hF6, 8'h08, 1'b0}, // 9  R5
        {4'b1000, 1'b0, 3'd0, 8'hF7, 8'h08, 1'b1}, // 10 R5 last window cycle
        {4'b1000, 1'b0, 3'd0, 8'hF6, 8'h09, 1'b0}, // 11 R5 act after T_RP
        {4'b1100, 1'b0, 3'd1, 8'hF6, 8'h09, 1'b1}, // 12 R10 two strobes
        {4'b0001, 1'b1, 3'd5, 8'h00, 8'h00, 1'b0}, // 13 R4 all banks
        {4'b0001, 1'b0, 3'd2, 8'h00, 8'h00, 1'b0}, // 14 R8 restart b2
        {4'b0000, 1'b0, 3'd0, 8'h00, 8'h00, 1'b0}, // 15
        {4'b0000, 1'b0, 3'd0, 8'h00, 8'h00, 1'b0}, // 16
        {4'b0000, 1'b0, 3'd0, 8'hFB, 8'h00, 1'b0}, // 17 R8 b2 still waiting
        {4'b0000, 1'b0, 3'd0, 8'hFF, 8'h00, 1'b0}, // 18 R8
        {4'b1000, 1'b0, 3'd7, 8'h7F, 8'h80, 1'b0}, // 19 R2 open b7
        {4'b0011, 1'b0, 3'd7, 8'h7F, 8'h80, 1'b1}, // 20 R10 wr+pre frozen
        {4'b0001, 1'b0, 3'd6, 8'h3F, 8'h80, 1'b0}, // 21 R8 pre idle b6
        {4'b0100, 1'b0, 3'd6, 8'h3F, 8'h80, 1'b1}  // 22 R7 read precharging
    };

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] c, input logic pa, input logic [2:0] ba);
        {cmd_act, cmd_rd, cmd_wr, cmd_pre} = c;
        pre_all   = pa;
        bank_addr = ba;
        @(posedge clk);
        @(negedge clk);
        {cmd_act, cmd_rd, cmd_wr, cmd_pre} = 4'b0000;
    endtask

    initial begin
        #200000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        {cmd_act, cmd_rd, cmd_wr, cmd_pre, pre_all} = '0;
        bank_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1", "act_ok", act_ok, 8'hFF);
        check("R1", "rw_ok", rw_ok, 8'h00);
        check("R1", "any_bank_active", 8'(any_bank_active), 8'h0);
        check("R1", "cmd_violation", 8'(cmd_violation), 8'h0);

        for (int i = 0; i < NV; i++) begin
            logic [24:0] v;
            v = VEC[i];
            drive(v[24:21], v[20], v[19:17]);
            check($sformatf("R2-group vec%0d", i), "act_ok", act_ok, v[16:9]);
            check($sformatf("R3-group vec%0d", i), "rw_ok", rw_ok, v[8:1]);
            check($sformatf("R11 vec%0d", i), "cmd_violation", 8'(cmd_violation), 8'(v[0]));
            check($sformatf("R9 vec%0d", i), "any_bank_active",
                  8'(any_bank_active), 8'(|v[8:1]));
        end

        // R11 back-to-back violations keep the flag high, then it drops
        drive(4'b1000, 1'b0, 3'd7);
        check("R11", "repeat violation", 8'(cmd_violation), 8'h1);
        drive(4'b0000, 1'b0, 3'd0);
        check("R11", "flag cleared", 8'(cmd_violation), 8'h0);

        // R1 reset in mid-activity returns every bank to idle
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", "act_ok after reset", act_ok, 8'hFF);
        check("R1", "rw_ok after reset", rw_ok, 8'h00);
        check("R9", "any after reset", 8'(any_bank_active), 8'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule